// File: doc/BRIEF.md
# Calendar Time Counter with Coherent Read and Write

This block keeps calendar time from a 100 Hz tick input. It counts hundredths of a second, seconds, minutes, hours, day of month, month, two-digit year and day of week. All values are plain binary. Software reaches it through a small parallel register bus with a 5-bit address, 8-bit data and separate read and write strobes.

Time is read and set in a way that keeps all fields consistent. A read of the hundredths register freezes a copy of the other seven fields, and later reads of those fields return the frozen copy while the live counters keep running. Writes to the seven upper fields only fill holding latches. A write to the hundredths register moves the held fields and the new hundredths value into the counters in one cycle. A command register selects the 12- or 24-hour format, a count enable, a tick divider and an accelerated test mode.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live time is 00:00:00.00, day 1, month 1, year 0, weekday 0. The frozen copy holds the same values. The command register reads 0x0C (24-hour, counting on). The read data output is 0.
- R2: Field addresses are 0 hundredths, 1 hours, 2 minutes, 3 seconds, 4 month, 5 day, 6 year, 7 weekday. The command register is at 0x11. Every other address reads 0. Read data appears on the output in the cycle after the read strobe and holds until the next read.
- R3: A read of address 0 returns the live hundredths value from before any tick in that cycle, and in the same cycle it freezes the other seven fields. Reads of addresses 1 to 7 return the frozen values until the next read of address 0, while the counters keep advancing.
- R4: A write to addresses 1 to 7 changes only a holding latch and leaves the live time alone. A write to address 0 loads the write data as hundredths and every held field into the live counters in one cycle.
- R5: Hundredths count 0 to 99, seconds and minutes count 0 to 59, and hours count 0 to 23. Each field carries into the next when it wraps.
- R6: The day wraps from the month's last day to 1. April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when year mod 4 is 0 and 28 otherwise.
- R7: The month wraps from 12 to 1 and advances the year, and the year wraps from 99 to 0. The weekday advances on every day rollover and wraps from 6 to 0.
- R8: With command bit 2 clear, hours are shown and written as 0 to 11 in bits 4:0, with bit 7 set for PM. A tick at 11 AM gives 0 PM (0x80). A tick at 11 PM gives 0 AM (0x00) and advances the day.
- R9: With command bit 3 clear, ticks have no effect on any field.
- R10: A value d in command bits 1:0 makes the time advance once per 2^d counted ticks. A write to the command register restarts this tick count.
- R11: With command bit 5 set, each advance adds one second directly and leaves hundredths unchanged.
- R12: If a write to address 0 and a tick arrive in the same cycle, the written time is loaded and the tick is dropped.
- R13: The command register keeps bits 0, 1, 2, 3 and 5 of a write. Bits 4, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at the 100 Hz time base |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 8 | Registered read data |

## Verification
The hardest cases to reach are the deep carry chains: year end in 23:59:59.99, leap-day February in 4-divisible and other years, and the 12-hour PM boundaries. Letting these occur by free counting would take far too long. Instead, the bench commits a time just before the boundary and then sends one tick. Two other cases need two strobes in the same cycle: a tick together with a commit, and a tick together with the snapshot read. The bench drives both strobes at the same falling edge. Random start dates, with random runs of up to a few hundred ticks, cover the ordinary carries.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam logic [6:0] HUND_LAST = 7'd99;
   localparam logic [5:0] SIXTY_LAST = 6'd59;
   localparam logic [4:0] HOUR_LAST = 5'd23;
   localparam logic [3:0] MON_LAST = 4'd12;
   localparam logic [6:0] YEAR_LAST = 7'd99;
   localparam logic [2:0] WDAY_LAST = 3'd6;

   typedef struct packed {
      logic [6:0] hund;
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
      logic [4:0] day;
      logic [3:0] mon;
      logic [6:0] year;
      logic [2:0] wday;
   } rtc_time_t;

   localparam rtc_time_t TIME_AT_RESET = '{hund: 7'd0, sec: 6'd0, min: 6'd0,
                                           hour: 5'd0, day: 5'd1, mon: 4'd1,
                                           year: 7'd0, wday: 3'd0};

   // days in a month outside the leap case
   function automatic logic [4:0] month_len(input logic [3:0] mon);
      case (mon)
         4'd2: month_len = 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
         default: month_len = 5'd31;
      endcase
   endfunction

   // bus view of one field; idx follows the register address
   function automatic logic [7:0] render(input rtc_time_t t, input logic [2:0] idx,
                                         input logic h24);
      logic [7:0] v;
      case (idx)
         3'd0: v = {1'b0, t.hund};
         3'd1: begin
            if (h24) v = {3'b000, t.hour};
            else if (t.hour >= 5'd12) v = {3'b100, t.hour - 5'd12};
            else v = {3'b000, t.hour};
         end
         3'd2: v = {2'b00, t.min};
         3'd3: v = {2'b00, t.sec};
         3'd4: v = {4'b0000, t.mon};
         3'd5: v = {3'b000, t.day};
         3'd6: v = {1'b0, t.year};
         default: v = {5'b00000, t.wday};
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             test_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             clr_i,
   output logic             adv_hund_o,
   output logic             adv_sec_o
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 2) else $error("DIV_W out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             fire;

   assign lim  = CNT_W'((32'd1 << div_i) - 32'd1);
   assign fire = tick_i && en_i && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (tick_i && en_i) begin
         cnt <= fire ? '0 : cnt + 1'b1;
      end
   end

   assign adv_hund_o = fire && !test_i;
   assign adv_sec_o  = fire && test_i;

   a_r9_off_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !(adv_hund_o || adv_sec_o));
   a_r11_test_skips_hund: assert property (@(posedge clk) disable iff (!rst_n)
      test_i |-> !adv_hund_o);
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_pkg::*;
#(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv_hund_i,
   input  logic      adv_sec_i,
   input  logic      load_i,
   input  rtc_time_t load_val_i,
   output rtc_time_t now_o
);
   rtc_time_t now;
   rtc_time_t nxt;
   logic [4:0] dim;
   logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;

   generate
      if (LEAP_EN) begin : g_leap
         assign dim = (now.mon == 4'd2 && now.year[1:0] == 2'b00) ? 5'd29
                                                                    : month_len(now.mon);
      end else begin : g_fixed
         assign dim = month_len(now.mon);
      end
   endgenerate

   always_comb begin
      nxt   = now;
      c_sec = adv_sec_i || (adv_hund_i && now.hund == HUND_LAST);
      if (adv_hund_i) nxt.hund = (now.hund == HUND_LAST) ? 7'd0 : now.hund + 7'd1;
      c_min = c_sec && now.sec == SIXTY_LAST;
      if (c_sec) nxt.sec = c_min ? 6'd0 : now.sec + 6'd1;
      c_hr = c_min && now.min == SIXTY_LAST;
      if (c_min) nxt.min = c_hr ? 6'd0 : now.min + 6'd1;
      c_day = c_hr && now.hour == HOUR_LAST;
      if (c_hr) nxt.hour = c_day ? 5'd0 : now.hour + 5'd1;
      c_mon = c_day && now.day == dim;
      if (c_day) begin
         nxt.day  = c_mon ? 5'd1 : now.day + 5'd1;
         nxt.wday = (now.wday == WDAY_LAST) ? 3'd0 : now.wday + 3'd1;
      end
      c_yr = c_mon && now.mon == MON_LAST;
      if (c_mon) nxt.mon = c_yr ? 4'd1 : now.mon + 4'd1;
      if (c_yr) nxt.year = (now.year == YEAR_LAST) ? 7'd0 : now.year + 7'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= TIME_AT_RESET;
      else if (load_i) now <= load_val_i;
      else now <= nxt;
   end

   assign now_o = now;

   a_r5_hund_range: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> now.hund <= HUND_LAST || $stable(now.hund));
   a_r5_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_hund_i || adv_sec_i) && now.hour <= HOUR_LAST |=> now.hour <= HOUR_LAST);
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_hund_i && !adv_sec_i && !load_i |=> $stable(now));
   a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> now == $past(load_val_i));
   a_r7_mon_range: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && now.mon >= 4'd1 && now.mon <= MON_LAST |=> now.mon >= 4'd1 && now.mon <= MON_LAST);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int CMD_ADDR = 17,
   parameter int DIV_W    = 2,
   parameter bit LEAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   output logic [DATA_W-1:0] bus_rdata_o
);
   localparam logic [7:0] CMD_MASK  = 8'h2F;
   localparam logic [7:0] CMD_RESET = 8'h0C;
   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

   initial begin
      assert (ADDR_W >= 4) else $error("ADDR_W too small");
      assert (DATA_W == 8) else $error("DATA_W must be 8");
      assert (CMD_ADDR > 7 && CMD_ADDR < (1 << ADDR_W)) else $error("CMD_ADDR out of range");
   end

   logic [7:0] cmd;
   logic       h24, cnt_en, test_en;
   logic       commit, cmd_wr, snap_rd, tick_ok;
   logic       adv_hund, adv_sec;
   rtc_time_t  now, load_val;

   logic       st_pm;
   logic [4:0] st_hour;
   logic [5:0] st_min, st_sec;
   logic [3:0] st_mon;
   logic [4:0] st_day;
   logic [6:0] st_year;
   logic [2:0] st_wday;

   logic [7:1][7:0] snap;
   logic [7:0]      rd_val;

   assign h24     = cmd[2];
   assign cnt_en  = cmd[3];
   assign test_en = cmd[5];
   assign commit  = bus_wr_i && bus_addr_i == '0;
   assign cmd_wr  = bus_wr_i && bus_addr_i == CMD_A;
   assign snap_rd = bus_rd_i && bus_addr_i == '0;
   assign tick_ok = tick_i && !commit;

   // command register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd <= CMD_RESET;
      else if (cmd_wr) cmd <= bus_wdata_i[7:0] & CMD_MASK;
   end

   // holding latches for the upper fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_pm   <= 1'b0;
         st_hour <= TIME_AT_RESET.hour;
         st_min  <= TIME_AT_RESET.min;
         st_sec  <= TIME_AT_RESET.sec;
         st_mon  <= TIME_AT_RESET.mon;
         st_day  <= TIME_AT_RESET.day;
         st_year <= TIME_AT_RESET.year;
         st_wday <= TIME_AT_RESET.wday;
      end else if (bus_wr_i) begin
         case (bus_addr_i)
            ADDR_W'(1): begin st_pm <= bus_wdata_i[7]; st_hour <= bus_wdata_i[4:0]; end
            ADDR_W'(2): st_min  <= bus_wdata_i[5:0];
            ADDR_W'(3): st_sec  <= bus_wdata_i[5:0];
            ADDR_W'(4): st_mon  <= bus_wdata_i[3:0];
            ADDR_W'(5): st_day  <= bus_wdata_i[4:0];
            ADDR_W'(6): st_year <= bus_wdata_i[6:0];
            ADDR_W'(7): st_wday <= bus_wdata_i[2:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      load_val.hund = bus_wdata_i[6:0];
      load_val.hour = (!h24 && st_pm) ? st_hour + 5'd12 : st_hour;
      load_val.min  = st_min;
      load_val.sec  = st_sec;
      load_val.mon  = st_mon;
      load_val.day  = st_day;
      load_val.year = st_year;
      load_val.wday = st_wday;
   end

   rtc_rate_gen #(.DIV_W(DIV_W)) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_ok),
      .en_i       (cnt_en),
      .test_i     (test_en),
      .div_i      (cmd[DIV_W-1:0]),
      .clr_i      (cmd_wr),
      .adv_hund_o (adv_hund),
      .adv_sec_o  (adv_sec)
   );

   rtc_time_core #(.LEAP_EN(LEAP_EN)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_hund_i (adv_hund),
      .adv_sec_i  (adv_sec),
      .load_i     (commit),
      .load_val_i (load_val),
      .now_o      (now)
   );

   // frozen copy of fields 1..7
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 1; k < 8; k++) snap[k] <= render(TIME_AT_RESET, 3'(k), 1'b1);
      end else if (snap_rd) begin
         for (int k = 1; k < 8; k++) snap[k] <= render(now, 3'(k), h24);
      end
   end

   always_comb begin
      rd_val = '0;
      if (bus_addr_i == '0) begin
         rd_val = render(now, 3'd0, h24);
      end else if (bus_addr_i == CMD_A) begin
         rd_val = cmd;
      end else begin
         for (int k = 1; k < 8; k++) begin
            if (bus_addr_i == ADDR_W'(k)) rd_val = snap[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= DATA_W'(rd_val);
   end

   a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_rd |=> $stable(snap));
   a_r12_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !(adv_hund || adv_sec));
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o));
   a_r13_cmd_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (cmd & ~CMD_MASK) == 8'h00);

endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] rdata;

   int checks = 0;
   int errs = 0;
   bit done = 1'b0;

   // reference time, kept by the bench from the requirements
   int mh, ms, mm, mhr, mdy, mmo, myr, mwd;
   bit m24, m_en, m_test;
   int m_div, m_cnt;

   always #4 clk = ~clk;

   rtc_calendar u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata)
   );

   function automatic int mdim(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] m_byte(int idx);
      case (idx)
         0: return 8'(mh);
         1: begin
            if (m24) return 8'(mhr);
            if (mhr >= 12) return 8'h80 | 8'(mhr - 12);
            return 8'(mhr);
         end
         2: return 8'(mm);
         3: return 8'(ms);
         4: return 8'(mmo);
         5: return 8'(mdy);
         6: return 8'(myr);
         default: return 8'(mwd);
      endcase
   endfunction

   task automatic m_day();
      mwd = (mwd == 6) ? 0 : mwd + 1;
      if (mdy >= mdim(mmo, myr)) begin
         mdy = 1;
         if (mmo == 12) begin mmo = 1; myr = (myr == 99) ? 0 : myr + 1; end
         else mmo++;
      end else mdy++;
   endtask

   task automatic m_sec();
      if (ms == 59) begin
         ms = 0;
         if (mm == 59) begin
            mm = 0;
            if (mhr == 23) begin mhr = 0; m_day(); end
            else mhr++;
         end else mm++;
      end else ms++;
   endtask

   task automatic m_tick();
      if (m_en) begin
         if (m_cnt >= (1 << m_div) - 1) begin
            m_cnt = 0;
            if (m_test) m_sec();
            else if (mh == 99) begin mh = 0; m_sec(); end
            else mh++;
         end else m_cnt++;
      end
   endtask

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; d = rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      m_tick();
   endtask

   task automatic set_cmd(input logic [7:0] v);
      bus_wr(5'h11, v);
      m24 = v[2]; m_en = v[3]; m_test = v[5]; m_div = int'(v[1:0]); m_cnt = 0;
   endtask

   task automatic set_time(int yr, int mo, int dy, int hr, int mi, int se, int hu, int wd);
      myr = yr; mmo = mo; mdy = dy; mhr = hr; mm = mi; ms = se; mh = hu; mwd = wd;
      for (int k = 1; k < 8; k++) bus_wr(5'(k), m_byte(k));
      bus_wr(5'd0, m_byte(0));
   endtask

   task automatic check_all(input string req);
      logic [7:0] d;
      bus_rd(5'd0, d); chk(req, d, m_byte(0));
      for (int k = 1; k < 8; k++) begin
         bus_rd(5'(k), d); chk(req, d, m_byte(k));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: got running expected finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] frozen [1:7];
      int hold;
      void'($urandom(32'd7170));
      mh = 0; ms = 0; mm = 0; mhr = 0; mdy = 1; mmo = 1; myr = 0; mwd = 0;
      m24 = 1; m_en = 1; m_test = 0; m_div = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk("R1 rdata", rdata, 8'h00);
      for (int k = 1; k < 8; k++) begin
         bus_rd(5'(k), d); chk("R1 frozen", d, m_byte(k));
      end
      bus_rd(5'h11, d); chk("R1 cmd", d, 8'h0C);
      bus_rd(5'd0, d); chk("R1 hund", d, 8'h00);

      // R13: spare command bits
      bus_wr(5'h11, 8'hFF);
      bus_rd(5'h11, d); chk("R13", d, 8'h2F);
      set_cmd(8'h0C);

      // R2: unmapped addresses
      bus_rd(5'd8, d); chk("R2 addr8", d, 8'h00);
      bus_rd(5'h1F, d); chk("R2 addr31", d, 8'h00);
      bus_rd(5'h10, d); chk("R2 addr16", d, 8'h00);

      // R3: frozen copy while counting continues
      set_time(21, 7, 9, 14, 30, 10, 97, 3);
      bus_rd(5'd0, d); chk("R3 live", d, m_byte(0));
      for (int k = 1; k < 8; k++) frozen[k] = m_byte(k);
      repeat (5) pulse_tick();
      for (int k = 1; k < 8; k++) begin
         bus_rd(5'(k), d); chk("R3 frozen", d, frozen[k]);
      end
      check_all("R3");
      // R3: tick in the same cycle as the freezing read
      hold = mh;
      @(negedge clk); addr = 5'd0; rd = 1'b1; tick = 1'b1;
      @(negedge clk); rd = 1'b0; tick = 1'b0; d = rdata;
      chk("R3 same-cycle", d, 8'(hold));
      m_tick();
      check_all("R3");

      // R4: holding latches do not touch live time
      set_time(30, 5, 20, 8, 20, 0, 0, 1);
      bus_wr(5'd2, 8'd33);
      check_all("R4");
      bus_wr(5'd0, 8'd5);
      mm = 33; mh = 5;
      check_all("R4");

      // R12: commit wins over tick
      set_time(30, 5, 20, 8, 20, 0, 10, 1);
      @(negedge clk); addr = 5'd0; wdata = 8'd50; wr = 1'b1; tick = 1'b1;
      @(negedge clk); wr = 1'b0; tick = 1'b0;
      mh = 50;
      check_all("R12");
      pulse_tick();
      bus_rd(5'd0, d); chk("R12 next", d, 8'd51);

      // R5: carries through to the hour
      set_time(10, 6, 10, 13, 59, 59, 99, 2); pulse_tick(); check_all("R5");
      // R6: month lengths and leap rule
      set_time(4, 2, 28, 23, 59, 59, 99, 0); pulse_tick(); check_all("R6");
      set_time(4, 2, 29, 23, 59, 59, 99, 1); pulse_tick(); check_all("R6");
      set_time(5, 2, 28, 23, 59, 59, 99, 2); pulse_tick(); check_all("R6");
      set_time(7, 4, 30, 23, 59, 59, 99, 3); pulse_tick(); check_all("R6");
      // R7: year end, weekday wrap
      set_time(99, 12, 31, 23, 59, 59, 99, 6); pulse_tick(); check_all("R7");

      // R8: 12-hour format
      set_cmd(8'h08);
      set_time(5, 3, 15, 11, 59, 59, 99, 6); pulse_tick(); check_all("R8");
      bus_rd(5'd1, d); chk("R8 noon", d, 8'h80);
      set_time(5, 3, 15, 23, 59, 59, 99, 6); pulse_tick(); check_all("R8");
      bus_rd(5'd1, d); chk("R8 midnight", d, 8'h00);
      set_time(5, 3, 15, 17, 1, 2, 3, 4); check_all("R8");
      set_cmd(8'h0C);

      // R9: counting off
      set_cmd(8'h04);
      set_time(1, 1, 1, 1, 1, 1, 40, 1);
      repeat (3) pulse_tick();
      check_all("R9");
      set_cmd(8'h0C);

      // R10: divide by 4
      set_cmd(8'h0E);
      set_time(1, 1, 1, 1, 1, 1, 0, 1);
      repeat (8) pulse_tick(); check_all("R10");
      repeat (3) pulse_tick(); check_all("R10");
      pulse_tick(); check_all("R10");
      set_cmd(8'h0C);

      // R11: accelerated mode
      set_cmd(8'h2C);
      set_time(40, 8, 31, 23, 59, 58, 40, 5);
      repeat (3) pulse_tick(); check_all("R11");
      set_cmd(8'h0C);

      // R5 R6 R7: random start times and run lengths
      for (int it = 0; it < 24; it++) begin
         int yr, mo, n;
         yr = int'($urandom % 100);
         mo = 1 + int'($urandom % 12);
         set_time(yr, mo, 1 + int'($urandom % mdim(mo, yr)), int'($urandom % 24),
                  int'($urandom % 60), int'($urandom % 60), int'($urandom % 100),
                  int'($urandom % 7));
         n = int'($urandom % 400);
         for (int t = 0; t < n; t++) pulse_tick();
         check_all("R5 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule